// File: doc/BRIEF.md
# Timed-Unlock Vector Base Select Register

An 8-bit control register that decides where the interrupt vector table starts. The table can sit at word 0 of program memory or at the first word of a boot section. A 2-bit boot-size fuse input picks one of four fixed boot-section starts. Moving the table takes two steps against a deadline. Software first arms a change-enable bit. It then writes the new select value, with the enable bit at 0, while the arm is still valid. The arm lapses on its own after four cycles.

While the arm is valid, and again after a select write until the next instruction retires, the block raises an interrupt-block output. This output masks interrupt acceptance without changing any global interrupt-enable flag, since the block holds no such flag. The same output also enforces the boot lock bits. It blocks interrupts while code runs in the region that does not own the vectors, whenever the lock bit for that region is programmed.

Top module: `vec_base_sel`

## Requirements
- R1: After reset every register bit reads 0. Read data bits 7..5 always read 0. Bits 4..2 are plain control bits that take the written value on every register write.
- R2: With the select bit (bit 1) at 0, `vec_base_o` is 0. With the select bit at 1, `vec_base_o` is the boot start chosen by `boot_size_i`: 0 gives 0xF00, 1 gives 0xE00, 2 gives 0xC00 and 3 gives 0x800 (word addresses, as parameters).
- R3: A write with bit 0 = 0 loads bit 1 into the select bit only if the change-enable bit reads 1 in that cycle. Otherwise the select bit keeps its value, but bits 4..2 are still updated.
- R4: A write with bit 0 = 1 sets the change-enable bit from the next cycle on and leaves the select bit unchanged. The enable bit stays set for four cycles and then clears, so a select write 1 to 4 cycles after the arming write takes effect and one 5 cycles after does not. It also clears right after a select write. Re-arming while it is set restarts the four cycles.
- R5: `irq_block_o` is 1 in every cycle in which the change-enable bit reads 1.
- R6: After a select write that takes effect, `irq_block_o` stays 1 until a cycle after the write in which `retire_i` is 1, and drops in the cycle after that retire.
- R7: With the select bit at 1, `lock_app_i` = 1 and `pc_in_boot_i` = 0, `irq_block_o` is 1.
- R8: With the select bit at 0, `lock_boot_i` = 1 and `pc_in_boot_i` = 1, `irq_block_o` is 1. When neither lock case of R7/R8 applies and no unlock is pending, `irq_block_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cycle clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| retire_i | input | 1 | Instruction-retire strobe |
| boot_size_i | input | 2 | Boot-size fuse field |
| lock_app_i | input | 1 | Boot lock bit guarding the application region |
| lock_boot_i | input | 1 | Boot lock bit guarding the boot region |
| pc_in_boot_i | input | 1 | 1 while the CPU executes from the boot section |
| vec_base_o | output | 12 | Word address of vector 0 |
| irq_block_o | output | 1 | Interrupt acceptance block |

## Verification
The unlock is driven with the select write placed 1, 2, 3 and 4 cycles after the arming write, and again at 5 cycles. This separates a window that is too short or too long from a correct four-cycle deadline. A re-arm in the middle of a window shows whether the window restarts or keeps counting from the first arm. A select write sent with no arming shows that the select bit is protected while the control bits still load. The retire strobe is held back for several cycles after a select write, so a blackout that ends on a fixed count can be told apart from one that waits for retirement. All four boot sizes are checked, and so are all combinations of select value, lock bits and execution region.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned CE_BIT = 0;
  localparam int unsigned SEL_BIT = 1;
  localparam int unsigned CTL_LO = 2;
  localparam int unsigned CTL_W  = 3;
  localparam int unsigned SIZE_W = 2;
endpackage

// File: rtl/vbs_unlock.sv
module vbs_unlock #(
  parameter int unsigned WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_ce_i,
  input  logic wr_sel_i,
  input  logic retire_i,
  output logic sel_o,
  output logic ce_o,
  output logic post_o
);
  localparam int unsigned CW = $clog2(WIN + 1);

  logic          sel_q, ce_q, post_q;
  logic [CW-1:0] cnt_q;
  logic          arm, commit;

  assign arm    = wr_en_i && wr_ce_i;
  assign commit = wr_en_i && !wr_ce_i && ce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      ce_q   <= 1'b0;
      post_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (arm) begin
        ce_q  <= 1'b1;
        cnt_q <= CW'(WIN);
      end else if (commit) begin
        sel_q <= wr_sel_i;
        ce_q  <= 1'b0;
        cnt_q <= '0;
      end else if (ce_q) begin
        // window counts down, enable lapses on the last cycle
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) ce_q <= 1'b0;
      end
      if (commit)                post_q <= 1'b1;
      else if (post_q && retire_i) post_q <= 1'b0;
    end
  end

  assign sel_o  = sel_q;
  assign ce_o   = ce_q;
  assign post_o = post_q;
endmodule

// File: rtl/vbs_base.sv
module vbs_base #(
  parameter int unsigned      AW     = 12,
  parameter logic [AW-1:0]    BASE_0 = 12'hF00,
  parameter logic [AW-1:0]    BASE_1 = 12'hE00,
  parameter logic [AW-1:0]    BASE_2 = 12'hC00,
  parameter logic [AW-1:0]    BASE_3 = 12'h800
) (
  input  logic                         sel_i,
  input  logic [vbs_pkg::SIZE_W-1:0]   size_i,
  output logic [AW-1:0]                base_o
);
  localparam int unsigned N = 1 << vbs_pkg::SIZE_W;

  logic [AW-1:0] starts [N];
  assign starts[0] = BASE_0;
  assign starts[1] = BASE_1;
  assign starts[2] = BASE_2;
  assign starts[3] = BASE_3;

  assign base_o = sel_i ? starts[size_i] : '0;
endmodule

// File: rtl/vbs_gate.sv
module vbs_gate (
  input  logic sel_i,
  input  logic ce_i,
  input  logic post_i,
  input  logic lock_app_i,
  input  logic lock_boot_i,
  input  logic pc_in_boot_i,
  output logic block_o
);
  logic lock_hit;

  // running outside the vector-owning region under its lock
  assign lock_hit = sel_i ? (lock_app_i && !pc_in_boot_i)
                          : (lock_boot_i && pc_in_boot_i);
  assign block_o  = ce_i || post_i || lock_hit;
endmodule

// File: rtl/vec_base_sel.sv
module vec_base_sel #(
  parameter int unsigned   WIN    = 4,
  parameter int unsigned   AW     = 12,
  parameter logic [AW-1:0] BASE_0 = 12'hF00,
  parameter logic [AW-1:0] BASE_1 = 12'hE00,
  parameter logic [AW-1:0] BASE_2 = 12'hC00,
  parameter logic [AW-1:0] BASE_3 = 12'h800
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [vbs_pkg::REG_W-1:0]   wr_data_i,
  output logic [vbs_pkg::REG_W-1:0]   rd_data_o,
  input  logic                        retire_i,
  input  logic [vbs_pkg::SIZE_W-1:0]  boot_size_i,
  input  logic                        lock_app_i,
  input  logic                        lock_boot_i,
  input  logic                        pc_in_boot_i,
  output logic [AW-1:0]               vec_base_o,
  output logic                        irq_block_o
);
  import vbs_pkg::*;

  logic [CTL_W-1:0] ctl_q;
  logic             sel, ce, post;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctl_q <= '0;
    else if (wr_en_i) ctl_q <= wr_data_i[CTL_LO +: CTL_W];
  end

  vbs_unlock #(.WIN(WIN)) u_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_ce_i  (wr_data_i[CE_BIT]),
    .wr_sel_i (wr_data_i[SEL_BIT]),
    .retire_i (retire_i),
    .sel_o    (sel),
    .ce_o     (ce),
    .post_o   (post)
  );

  vbs_base #(
    .AW(AW), .BASE_0(BASE_0), .BASE_1(BASE_1), .BASE_2(BASE_2), .BASE_3(BASE_3)
  ) u_base (
    .sel_i  (sel),
    .size_i (boot_size_i),
    .base_o (vec_base_o)
  );

  vbs_gate u_gate (
    .sel_i        (sel),
    .ce_i         (ce),
    .post_i       (post),
    .lock_app_i   (lock_app_i),
    .lock_boot_i  (lock_boot_i),
    .pc_in_boot_i (pc_in_boot_i),
    .block_o      (irq_block_o)
  );

  assign rd_data_o = {{(REG_W - CTL_LO - CTL_W){1'b0}}, ctl_q, sel, ce};
endmodule

// File: rtl/vbs_checker.sv
module vbs_checker #(
  parameter int unsigned AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [7:0]    wr_data_i,
  input logic [7:0]    rd_data_o,
  input logic          lock_app_i,
  input logic          lock_boot_i,
  input logic          pc_in_boot_i,
  input logic [AW-1:0] vec_base_o,
  input logic          irq_block_o
);
  p_hi_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:5] == 3'b000);

  p_base_app_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[1] |-> vec_base_o == '0);

  p_sel_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[0] |=> $stable(rd_data_o[1]));

  p_ce_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[0] && wr_en_i && !wr_data_i[0]) |=> !rd_data_o[0]);

  p_ce_arm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[0]) |=> (rd_data_o[0] && $stable(rd_data_o[1])));

  p_block_ce_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[0] |-> irq_block_o);

  p_lock_app_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[1] && lock_app_i && !pc_in_boot_i) |-> irq_block_o);

  p_lock_boot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[1] && lock_boot_i && pc_in_boot_i) |-> irq_block_o);
endmodule

bind vec_base_sel vbs_checker #(.AW(AW)) u_vbs_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .rd_data_o    (rd_data_o),
  .lock_app_i   (lock_app_i),
  .lock_boot_i  (lock_boot_i),
  .pc_in_boot_i (pc_in_boot_i),
  .vec_base_o   (vec_base_o),
  .irq_block_o  (irq_block_o)
);

// File: tb/vec_base_sel_bench.sv
`timescale 1ns/1ps
module vec_base_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        retire = 1'b0;
  logic [1:0]  boot_size = '0;
  logic        lock_app = 1'b0, lock_boot = 1'b0, pc_boot = 1'b0;
  logic [11:0] vec_base;
  logic        irq_block;

  int n_chk = 0, n_bad = 0;
  bit comparing = 1'b0;

  // reference state
  int m_sel = 0, m_ctl = 0, m_ce = 0, m_age = 0, m_post = 0;

  always #2 clk = ~clk;

  vec_base_sel u_vec_base_sel (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .retire_i(retire), .boot_size_i(boot_size),
    .lock_app_i(lock_app), .lock_boot_i(lock_boot), .pc_in_boot_i(pc_boot),
    .vec_base_o(vec_base), .irq_block_o(irq_block)
  );

  function automatic int boot_start(int sz);
    case (sz)
      0: return 'hF00;
      1: return 'hE00;
      2: return 'hC00;
      default: return 'h800;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      int clr_post;
      clr_post = (m_post != 0 && retire) ? 1 : 0;
      if (wr_en) begin
        m_ctl = int'(wr_data[4:2]);
        if (wr_data[0]) begin
          m_ce = 1; m_age = 0;
        end else if (m_ce != 0) begin
          m_sel = int'(wr_data[1]); m_ce = 0; m_post = 1; clr_post = 0;
        end
      end else if (m_ce != 0) begin
        m_age++;
        if (m_age == 4) m_ce = 0;
      end
      if (clr_post != 0) m_post = 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (comparing) begin
      int lk, blk;
      lk  = (m_sel != 0) ? int'(lock_app && !pc_boot) : int'(lock_boot && pc_boot);
      blk = (m_ce != 0 || m_post != 0 || lk != 0) ? 1 : 0;
      check("R1 hi bits", int'(rd_data[7:5]), 0);
      check("R1 R3 ctl bits", int'(rd_data[4:2]), m_ctl);
      check("R3 select bit", int'(rd_data[1]), m_sel);
      check("R4 change enable", int'(rd_data[0]), m_ce);
      check("R2 vec_base", int'(vec_base), (m_sel != 0) ? boot_start(int'(boot_size)) : 0);
      check("R5 R6 R7 R8 irq_block", int'(irq_block), blk);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #0.5;
      wr_en = 1'b0; retire = 1'b0;
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); #0.5;
    wr_en = 1'b1; wr_data = d; retire = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk); #0.5;
    wr_en = 1'b0; retire = 1'b1;
  endtask

  initial begin
    #20000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic cur;
    repeat (3) @(negedge clk);
    check("R1 reset read", int'(rd_data), 0);
    check("R1 reset block", int'(irq_block), 0);
    #0.5 rst_n = 1'b1;
    comparing = 1'b1;
    idle(2);
    // R3: protected select, control bits still load
    wr(8'b0001_0110); idle(2);
    wr(8'b0000_1010); idle(2);
    // R4 valid unlock at offsets 1..4, R6 late retire
    cur = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      cur = ~cur;
      wr(8'h01);
      idle(k - 1);
      wr({6'b000100, cur, 1'b0});
      idle(3); ret(); idle(2);
    end
    // R4 expired at offset 5
    wr(8'h01); idle(4); wr(8'h02); idle(2); ret(); idle(2);
    // R4 restart of window
    wr(8'h01); idle(3); wr(8'h01); idle(3); wr(8'h02); idle(1); ret(); ret(); idle(2);
    // R2 all boot sizes with select = 1
    for (int s = 0; s < 4; s++) begin
      boot_size = 2'(s); idle(2);
    end
    // R7 R8 every lock/region pairing for both selects
    for (int v = 0; v < 2; v++) begin
      wr(8'h01); wr({6'b0, v[0], 1'b0}); ret(); idle(2);
      for (int c = 0; c < 8; c++) begin
        @(negedge clk); #0.5;
        lock_app = c[0]; lock_boot = c[1]; pc_boot = c[2];
        idle(1);
      end
      lock_app = 1'b0; lock_boot = 1'b0; pc_boot = 1'b0;
    end
    idle(3);
    comparing = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule